// File: doc/BRIEF.md
# Output Color Matrix Converter

This block sits on a per-pixel video stream and converts every RGB pixel into three output channels through a 3x4 affine matrix. Each row of the matrix has three multiply terms and one additive offset. A 3-bit mode value chooses where the matrix comes from: pass-through, one of three fixed matrices (full-to-limited-range RGB, BT.601 RGB-to-YCbCr, BT.709 RGB-to-YCbCr), or a matrix that software loads through a 32-bit register write port.

Software writes go into a pending bank. The pending bank is copied into the active bank only on a frame-start pulse, so every frame is converted with one consistent set of settings. The pixel path is a fixed three-stage pipeline. A valid flag and a sync sideband bit travel alongside the data with the same delay.

Top module: `color_matrix_conv`

## Requirements
- R1: While `rst` is high and after it is released, `out_valid`, `out_sync` and all three output channels are 0. Pending and active settings reset to mode 0 and to all-zero coefficients. Selecting mode 4 without loading any coefficients therefore produces 0 on every channel.
- R2: A pixel sampled on a rising edge appears on the outputs after the third rising edge from that edge. `out_valid` and `out_sync` repeat `in_valid` and `in_sync` with the same three-edge delay, including gaps in the stream.
- R3: Mode 0 passes pixels through unchanged: out_c0 = R, out_c1 = G, out_c2 = B.
- R4: Mode 1 scales each channel by 0x1B60 and adds offset 0x200. The scale sits on the diagonal entries C11, C22 and C33. The offset sits in C14, C24 and C34. All other entries are 0.
- R5: Mode 2 uses these fixed entries. Row 1: 0x0E00, 0xF447, 0xFDB9, 0x1000. Row 2: 0x082F, 0x1012, 0x031F, 0x0200. Row 3: 0xFB47, 0xF6B9, 0x0E00, 0x1000.
- R6: Mode 3 uses these fixed entries. Row 1: 0x0E00, 0xF349, 0xFEB7, 0x1000. Row 2: 0x05D2, 0x1394, 0x01FA, 0x0200. Row 3: 0xFCCB, 0xF535, 0x0E00, 0x1000.
- R7: Mode 4 uses the software matrix. Write addresses 0 to 5 hold the coefficient pairs (C11,C12), (C13,C14), (C21,C22), (C23,C24), (C31,C32) and (C33,C34). The first entry of each pair goes in bits 15:0 and the second in bits 31:16. Address 6 holds the mode in bits 2:0. A write to address 7 has no effect.
- R8: Output row i (out_c0 for row 1, out_c1 for row 2, out_c2 for row 3) is computed as ((Ci1*R + Ci2*G + Ci3*B + Ci4*1024 + 4096) >> 13), using an arithmetic shift. Ci1..Ci3 are signed 16-bit values with 13 fractional bits, so 0x2000 means 1.0. Ci4 is a signed offset with 13 fractional bits, where 1.0 equals 1024 pixel codes.
- R9: A result below 0 is clamped to 0, and a result above 1023 is clamped to 1023.
- R10: Register writes change nothing on the outputs until `frame_start` is high on a rising edge. A pixel sampled on that same edge still uses the old settings. Pixels sampled on later edges use the pending settings as they stood before that edge.
- R11: Mode codes 5, 6 and 7 behave exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Copies pending settings into the active bank |
| in_valid | input | 1 | Input pixel valid |
| in_sync | input | 1 | Input sync sideband |
| in_r | input | 10 | Red component |
| in_g | input | 10 | Green component |
| in_b | input | 10 | Blue component |
| out_valid | output | 1 | Output pixel valid |
| out_sync | output | 1 | Delayed sync sideband |
| out_c0 | output | 10 | Output channel from matrix row 1 |
| out_c1 | output | 10 | Output channel from matrix row 2 |
| out_c2 | output | 10 | Output channel from matrix row 3 |

## Verification
The hardest case to reach is the frame boundary. Here a full new matrix and a new mode are pending while the old ones are still active, and a valid pixel arrives in the same cycle as `frame_start`. The stimulus programs all six words and the mode while pass-through is active, streams pixels that must stay unconverted, and then raises `frame_start` together with a valid pixel. It then checks that this pixel uses the old settings and the next one uses the new settings. Clamping on both sides is reached with extreme loaded coefficients and offsets, and rounding is covered by an exhaustive sweep of one channel through a half-scale coefficient.

// File: rtl/cmc_pkg.sv
`timescale 1ns/1ps
package cmc_pkg;
  localparam int COEF_W = 16;
  localparam int FRAC_W = 13;
  localparam int N_COEF = 12;
  localparam int MODE_W = 3;

  typedef logic [N_COEF-1:0][COEF_W-1:0] mat_t;

  typedef enum logic [MODE_W-1:0] {
    MODE_PASS    = 3'd0,
    MODE_LIMITED = 3'd1,
    MODE_BT601   = 3'd2,
    MODE_BT709   = 3'd3,
    MODE_USER    = 3'd4
  } mode_e;

  // entry k = row*4 + column; column 3 is the offset
  function automatic mat_t fixed_matrix(input logic [MODE_W-1:0] mode);
    mat_t m;
    m = '0;
    case (mode)
      MODE_LIMITED: begin
        m[0] = 16'h1B60; m[5] = 16'h1B60; m[10] = 16'h1B60;
        m[3] = 16'h0200; m[7] = 16'h0200; m[11] = 16'h0200;
      end
      MODE_BT601: begin
        m[0] = 16'h0E00; m[1] = 16'hF447; m[2]  = 16'hFDB9; m[3]  = 16'h1000;
        m[4] = 16'h082F; m[5] = 16'h1012; m[6]  = 16'h031F; m[7]  = 16'h0200;
        m[8] = 16'hFB47; m[9] = 16'hF6B9; m[10] = 16'h0E00; m[11] = 16'h1000;
      end
      MODE_BT709: begin
        m[0] = 16'h0E00; m[1] = 16'hF349; m[2]  = 16'hFEB7; m[3]  = 16'h1000;
        m[4] = 16'h05D2; m[5] = 16'h1394; m[6]  = 16'h01FA; m[7]  = 16'h0200;
        m[8] = 16'hFCCB; m[9] = 16'hF535; m[10] = 16'h0E00; m[11] = 16'h1000;
      end
      default: begin
        m[0] = 16'h2000; m[5] = 16'h2000; m[10] = 16'h2000;
      end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/cmc_regfile.sv
`timescale 1ns/1ps
module cmc_regfile
  import cmc_pkg::*;
#(
  parameter int CFG_AW = 3,
  parameter int CFG_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  input  logic              commit,
  output mat_t              user_mat,
  output logic [MODE_W-1:0] act_mode
);
  localparam int NUM_WORDS = N_COEF / 2;
  localparam int MODE_ADDR = NUM_WORDS;

  logic [NUM_WORDS-1:0][CFG_DW-1:0] pend_q, act_q;
  logic [MODE_W-1:0]                pend_mode_q, act_mode_q;

  generate
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst) begin
          pend_q[w] <= '0;
          act_q[w]  <= '0;
        end else begin
          if (commit) act_q[w] <= pend_q[w];
          if (we && addr == CFG_AW'(w)) pend_q[w] <= wdata;
        end
      end
      assign user_mat[2*w]   = act_q[w][COEF_W-1:0];
      assign user_mat[2*w+1] = act_q[w][2*COEF_W-1:COEF_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mode_q <= '0;
      act_mode_q  <= '0;
    end else begin
      if (commit) act_mode_q <= pend_mode_q;
      if (we && addr == CFG_AW'(MODE_ADDR)) pend_mode_q <= wdata[MODE_W-1:0];
    end
  end

  assign act_mode = act_mode_q;

  // R10
  hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_mode_q));
  // R10
  hold_coef_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_q));
  // R10
  commit_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> act_q == $past(pend_q));
endmodule

// File: rtl/cmc_coef_mux.sv
`timescale 1ns/1ps
module cmc_coef_mux
  import cmc_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  mat_t              user_mat,
  output mat_t              sel_mat
);
  always_comb begin
    if (mode == MODE_USER) sel_mat = user_mat;
    else                   sel_mat = fixed_matrix(mode);
  end
endmodule

// File: rtl/cmc_row.sv
`timescale 1ns/1ps
module cmc_row
  import cmc_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2:0][PIX_W-1:0]  px,
  input  logic [3:0][COEF_W-1:0] coef,
  output logic [PIX_W-1:0]       res
);
  localparam int PROD_W = PIX_W + 1 + COEF_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(2 ** (FRAC_W - 1));
  localparam logic signed [SUM_W-1:0] TOP  = SUM_W'(2 ** PIX_W - 1);

  logic signed [PROD_W-1:0] prod_q [3];
  logic signed [COEF_W-1:0] off_q;
  logic signed [SUM_W-1:0]  sum_c, rnd_q;

  // stage 1: products and offset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < 3; j++) prod_q[j] <= '0;
      off_q <= '0;
    end else begin
      for (int j = 0; j < 3; j++)
        prod_q[j] <= PROD_W'($signed({1'b0, px[j]})) * PROD_W'($signed(coef[j]));
      off_q <= $signed(coef[3]);
    end
  end

  // stage 2: accumulate, scale offset to pixel range, round
  always_comb begin
    sum_c = SUM_W'(prod_q[0]) + SUM_W'(prod_q[1]) + SUM_W'(prod_q[2])
          + (SUM_W'(off_q) <<< PIX_W) + HALF;
  end

  always_ff @(posedge clk) begin
    if (rst) rnd_q <= '0;
    else     rnd_q <= sum_c >>> FRAC_W;
  end

  // stage 3: clamp
  always_ff @(posedge clk) begin
    if (rst)                 res <= '0;
    else if (rnd_q[SUM_W-1]) res <= '0;
    else if (rnd_q > TOP)    res <= '1;
    else                     res <= rnd_q[PIX_W-1:0];
  end

  // R9
  clamp_low_chk: assert property (@(posedge clk) disable iff (rst)
    rnd_q[SUM_W-1] |=> res == '0);
  // R9
  clamp_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!rnd_q[SUM_W-1] && rnd_q > TOP) |=> res == '1);
endmodule

// File: rtl/color_matrix_conv.sv
`timescale 1ns/1ps
module color_matrix_conv
  import cmc_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int CFG_AW = 3,
  parameter int CFG_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              frame_start,
  input  logic              in_valid,
  input  logic              in_sync,
  input  logic [PIX_W-1:0]  in_r,
  input  logic [PIX_W-1:0]  in_g,
  input  logic [PIX_W-1:0]  in_b,
  output logic              out_valid,
  output logic              out_sync,
  output logic [PIX_W-1:0]  out_c0,
  output logic [PIX_W-1:0]  out_c1,
  output logic [PIX_W-1:0]  out_c2
);
  localparam int PIPE = 3;
  localparam int CH   = 3;

  mat_t              user_mat, sel_mat;
  logic [MODE_W-1:0] act_mode;

  cmc_regfile #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .commit   (frame_start),
    .user_mat (user_mat),
    .act_mode (act_mode)
  );

  cmc_coef_mux u_mux (
    .mode     (act_mode),
    .user_mat (user_mat),
    .sel_mat  (sel_mat)
  );

  logic [CH-1:0][PIX_W-1:0] px_in, px_out;
  assign px_in = {in_b, in_g, in_r};

  generate
    for (genvar i = 0; i < CH; i++) begin : g_row
      cmc_row #(.PIX_W(PIX_W)) u_row (
        .clk  (clk),
        .rst  (rst),
        .px   (px_in),
        .coef (sel_mat[4*i +: 4]),
        .res  (px_out[i])
      );
    end
  endgenerate

  logic [PIPE-1:0] vld_sr, sync_sr;
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_sr  <= '0;
      sync_sr <= '0;
    end else begin
      vld_sr  <= {vld_sr[PIPE-2:0], in_valid};
      sync_sr <= {sync_sr[PIPE-2:0], in_sync};
    end
  end

  assign out_valid = vld_sr[PIPE-1];
  assign out_sync  = sync_sr[PIPE-1];
  assign out_c0    = px_out[0];
  assign out_c1    = px_out[1];
  assign out_c2    = px_out[2];

  // edges seen since reset, saturating, so that $past never reaches into reset
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)              warm_q <= '0;
    else if (warm_q != 3) warm_q <= warm_q + 2'd1;
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    warm_q == 3 |-> out_valid == $past(in_valid, 3));
  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    warm_q == 3 |-> out_sync == $past(in_sync, 3));
  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 3 && $past(act_mode == MODE_PASS || act_mode > MODE_USER, 3))
      |-> (out_c0 == $past(in_r, 3) && out_c1 == $past(in_g, 3) && out_c2 == $past(in_b, 3)));
endmodule

// File: tb/color_matrix_conv_test.sv
`timescale 1ns/1ps
module color_matrix_conv_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        in_valid = 1'b0, in_sync = 1'b0;
  logic [9:0]  in_r = '0, in_g = '0, in_b = '0;
  logic        out_valid, out_sync;
  logic [9:0]  out_c0, out_c1, out_c2;

  always #10 clk = ~clk;

  color_matrix_conv uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .in_valid(in_valid), .in_sync(in_sync),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid), .out_sync(out_sync),
    .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
  );

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // fixed tables from R4..R6, identity for pass-through
  logic [15:0] t_lim [12] = '{16'h1B60,0,0,16'h0200, 0,16'h1B60,0,16'h0200, 0,0,16'h1B60,16'h0200};
  logic [15:0] t_601 [12] = '{16'h0E00,16'hF447,16'hFDB9,16'h1000, 16'h082F,16'h1012,16'h031F,16'h0200,
                              16'hFB47,16'hF6B9,16'h0E00,16'h1000};
  logic [15:0] t_709 [12] = '{16'h0E00,16'hF349,16'hFEB7,16'h1000, 16'h05D2,16'h1394,16'h01FA,16'h0200,
                              16'hFCCB,16'hF535,16'h0E00,16'h1000};
  logic [15:0] t_id  [12] = '{16'h2000,0,0,0, 0,16'h2000,0,0, 0,0,16'h2000,0};

  // bench model of the two register banks
  logic [31:0] m_pend [6];
  logic [31:0] m_act  [6];
  int          m_pend_mode = 0, m_act_mode = 0;

  // expectation slots indexed by issue cycle
  int    s_cyc [8];
  bit    s_v [8], s_s [8];
  int    s_e0 [8], s_e1 [8], s_e2 [8];
  string s_req [8];

  initial begin
    for (int i = 0; i < 8; i++) s_cyc[i] = -100;
    for (int i = 0; i < 6; i++) begin m_pend[i] = '0; m_act[i] = '0; end
  end

  function automatic int coef_at(int k);
    logic [15:0] h;
    if (m_act_mode == 4) begin
      h = (k % 2 == 1) ? m_act[k/2][31:16] : m_act[k/2][15:0];
    end else begin
      case (m_act_mode)
        1: h = t_lim[k];
        2: h = t_601[k];
        3: h = t_709[k];
        default: h = t_id[k];
      endcase
    end
    return int'($signed(h));
  endfunction

  // R8 arithmetic with R9 clamp
  function automatic int model_row(int row, int r, int g, int b);
    int s;
    s = coef_at(4*row)*r + coef_at(4*row+1)*g + coef_at(4*row+2)*b + coef_at(4*row+3)*1024 + 4096;
    s = s >>> 13;
    if (s < 0) s = 0;
    if (s > 1023) s = 1023;
    return s;
  endfunction

  task automatic step(input bit we, input int a, input logic [31:0] d, input bit fs,
                      input bit v, input bit sy, input int r, input int g, input int b,
                      input string req);
    int sl;
    @(negedge clk);
    sl = cyc % 8;
    s_cyc[sl] = cyc; s_v[sl] = v; s_s[sl] = sy; s_req[sl] = req;
    s_e0[sl] = model_row(0, r, g, b);
    s_e1[sl] = model_row(1, r, g, b);
    s_e2[sl] = model_row(2, r, g, b);
    cfg_we = we; cfg_addr = 3'(a); cfg_wdata = d; frame_start = fs;
    in_valid = v; in_sync = sy; in_r = 10'(r); in_g = 10'(g); in_b = 10'(b);
    if (fs) begin
      for (int i = 0; i < 6; i++) m_act[i] = m_pend[i];
      m_act_mode = m_pend_mode;
    end
    if (we) begin
      if (a < 6) m_pend[a] = d;
      else if (a == 6) m_pend_mode = int'(d[2:0]);
    end
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2"); endtask
  task automatic wr(int a, logic [31:0] d); step(1, a, d, 0, 0, 0, 0, 0, 0, "R2"); endtask
  task automatic commit(); step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R2"); endtask
  task automatic pix(int r, int g, int b, string req); step(0, 0, 0, 0, 1, r[0], r, g, b, req); endtask

  int n_pix = 0;
  task automatic grid(int stp, string req);
    for (int r = 0; r < 1024; r += stp)
      for (int g = 0; g < 1024; g += stp)
        for (int b = 0; b < 1024; b += stp) begin
          step(0, 0, 0, 0, 1, (n_pix % 5 == 0), r, g, b, req);
          if (n_pix % 7 == 6) idle();
          n_pix++;
        end
  endtask

  task automatic load(logic [31:0] w0, logic [31:0] w1, logic [31:0] w2,
                      logic [31:0] w3, logic [31:0] w4, logic [31:0] w5);
    wr(0, w0); wr(1, w1); wr(2, w2); wr(3, w3); wr(4, w4); wr(5, w5);
  endtask

  // output checker
  always @(negedge clk) begin
    int sl;
    if (!rst && cyc >= 3) begin
      sl = (cyc - 3) % 8;
      if (s_cyc[sl] == cyc - 3) begin
        vectors++;
        if (out_valid !== s_v[sl] || out_sync !== s_s[sl]) begin
          fails++;
          $display("FAIL R2: valid/sync got %b/%b exp %b/%b", out_valid, out_sync, s_v[sl], s_s[sl]);
        end else if (s_v[sl] && (int'(out_c0) != s_e0[sl] || int'(out_c1) != s_e1[sl] || int'(out_c2) != s_e2[sl])) begin
          fails++;
          $display("FAIL %s: got %0d %0d %0d exp %0d %0d %0d", s_req[sl],
                   out_c0, out_c1, out_c2, s_e0[sl], s_e1[sl], s_e2[sl]);
        end
      end
    end
  end

  task automatic reset_check();
    vectors++;
    if (out_valid !== 1'b0 || out_sync !== 1'b0 || out_c0 !== '0 || out_c1 !== '0 || out_c2 !== '0) begin
      fails++;
      $display("FAIL R1: reset outputs got %b %b %0d %0d %0d exp 0 0 0 0 0",
               out_valid, out_sync, out_c0, out_c1, out_c2);
    end
  endtask

  initial begin
    int modes [7] = '{0, 1, 2, 3, 5, 6, 7};
    string tags [7] = '{"R3", "R4", "R5", "R6", "R11", "R11", "R11"};
    repeat (3) @(negedge clk);
    reset_check();
    rst = 1'b0;
    @(negedge clk);
    reset_check();

    // R1: default is pass-through
    for (int i = 0; i < 8; i++) pix(i * 131, 1023 - i * 97, i * 55, "R1");
    // R1: coefficients reset to zero
    wr(6, 4); commit();
    for (int i = 0; i < 8; i++) pix(1023 - i, i * 120, 600, "R1");

    // fixed modes and out-of-range codes
    for (int m = 0; m < 7; m++) begin
      wr(6, modes[m]); commit();
      grid(93, tags[m]);
    end

    // R10: load a user matrix while pass-through (mode 7) is active
    load(32'h0800_1000, 32'h0100_FC00, 32'h2000_F000, 32'h0400_0400, 32'hE000_0000, 32'hF000_4000);
    wr(6, 32'hFFFF_FFF4);
    for (int i = 0; i < 20; i++) pix(i * 51, 1000 - i * 40, i * 13, "R10");
    step(0, 0, 0, 1, 1, 1, 700, 300, 900, "R10");
    for (int i = 0; i < 20; i++) pix(i * 51, 1000 - i * 40, i * 13, "R10");
    grid(341, "R7");

    // R7: address 7 is ignored
    wr(7, 32'hFFFF_FFFF); commit();
    grid(341, "R7");

    // R8: rounding, C11 = 0.5, red channel swept exhaustively
    load(32'h0000_1000, 0, 0, 0, 0, 0); commit();
    for (int r = 0; r < 1024; r++) pix(r, (r * 37) % 1024, (r * 101 + 7) % 1024, "R8");

    // R9: extreme coefficients and offsets
    load(32'h0000_7FFF, 32'hE000_0000, 32'h8000_0000, 0, 0, 32'h1FFF_2000); commit();
    grid(93, "R9");

    repeat (6) idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule